// File: doc/BRIEF.md
# Interlaced 1080-Line Raster Timing Generator

This block produces the horizontal and vertical timing for a 1920x1080 interlaced raster. A pixel counter walks across each line. A line counter walks through one field, first the picture lines and then that field's vertical blanking. A field bit tells the two fields apart. From these counters the block decodes horizontal sync, vertical sync and data-enable, and it outputs the image row that the current active line carries. Upstream pixel logic uses that row number and the pixel counter to compute each pixel on the fly, so no frame store is needed.

Field 0 carries the even image rows 0, 2, ... 1078 and is followed by 23 blanking lines. Field 1 carries the odd rows 1, 3, ... 1079 and is followed by 22 blanking lines. In both blanking intervals vertical sync lasts two full line periods and rises in the third blanking line. In field 0 it rises at the middle of that line. In field 1 it rises at the start of that line. A display reads this half-line phase difference as the field identity. The nominal pixel clock is 74.25 MHz and a line is 2200 clocks long.

All widths and the raster geometry are parameters. The interface is timing only and has no data stream, so it carries no valid/ready handshake. Every output is a plain decode of registered counter state and takes effect in the same cycle as that state.

Top module: `vtg_interlaced`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `h_pos`=0, `line_pos`=0 and `field`=0. A reset in mid-frame returns the block to this state.
- R2: `h_pos` rises by one each clock from 0 to H_TOTAL-1 and then wraps to 0. H_TOTAL = H_ACTIVE+H_FRONT+H_SYNC+H_BACK, which is 2200 by default.
- R3: `hsync` is high (active-high) exactly when H_ACTIVE+H_FRONT <= `h_pos` < H_ACTIVE+H_FRONT+H_SYNC.
- R4: `de` is high exactly when `line_pos` < FIELD_ROWS and `h_pos` < H_ACTIVE.
- R5: When `de` is high, `row` = 2*`line_pos` + `field`. This gives even rows in field 0 and odd rows in field 1. When `de` is low, `row` is 0.
- R6: `line_pos` advances when `h_pos` wraps. Field 0 spans FIELD_ROWS+BLANK_EVEN lines (540+23) and field 1 spans FIELD_ROWS+BLANK_ODD lines (540+22). `field` toggles only when `line_pos` wraps to 0.
- R7: In field 0, `vsync` rises at `h_pos` = H_TOTAL/2 of blanking line VS_LINE, counted from 0, which is the third blanking line by default.
- R8: In field 1, `vsync` rises at `h_pos` = 0 of blanking line VS_LINE.
- R9: `vsync` stays high for exactly VS_LINES*H_TOTAL clocks and is never high during a picture line. It falls at the same horizontal offset at which it rose, VS_LINES lines later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| h_pos | output | $clog2(H_TOTAL) | Pixel position within the line |
| line_pos | output | $clog2(FIELD_ROWS+max blank) | Line position within the current field, blanking included |
| field | output | 1 | 0 = even-row field, 1 = odd-row field |
| row | output | $clog2(2*FIELD_ROWS) | Image row of the current active line |
| de | output | 1 | Data enable, high on active pixels |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |

## Verification
The hardest behaviour to reach is the last stretch of each field: the half-line vsync edges, the boundary where the blanking length differs between fields, and the field toggle. A default-sized frame takes over two million clocks to get there. The bench therefore builds the block with a small raster: a 16-clock line, four picture rows per field, and blanking lengths of 6 and 5 lines. It then sweeps two complete frames clock by clock, comparing every output against positions derived arithmetically from the elapsed cycle count. A reset in mid-frame then shows the return to the origin.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  typedef enum logic {
    FIELD_EVEN = 1'b0,
    FIELD_ODD  = 1'b1
  } field_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/vtg_hcount.sv
module vtg_hcount #(
  parameter int unsigned H_TOTAL = 2200,
  localparam int unsigned HW = $clog2(H_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] h_q,
  output logic          h_last
);
  localparam logic [HW-1:0] H_END = HW'(H_TOTAL - 1);

  assign h_last = (h_q == H_END);

  always_ff @(posedge clk) begin
    if (!rst_n)      h_q <= '0;
    else if (h_last) h_q <= '0;
    else             h_q <= h_q + 1'b1;
  end
endmodule

// File: rtl/vtg_vcount.sv
module vtg_vcount
  import vtg_pkg::*;
#(
  parameter int unsigned FIELD_ROWS = 540,
  parameter int unsigned BLANK_EVEN = 23,
  parameter int unsigned BLANK_ODD  = 22,
  localparam int unsigned LW = $clog2(FIELD_ROWS + max_u(BLANK_EVEN, BLANK_ODD))
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [LW-1:0] line_q,
  output field_e        field_q
);
  localparam logic [LW-1:0] END_EVEN = LW'(FIELD_ROWS + BLANK_EVEN - 1);
  localparam logic [LW-1:0] END_ODD  = LW'(FIELD_ROWS + BLANK_ODD - 1);

  logic          at_end;
  logic [LW-1:0] end_sel;

  assign end_sel = (field_q == FIELD_EVEN) ? END_EVEN : END_ODD;
  assign at_end  = (line_q == end_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q  <= '0;
      field_q <= FIELD_EVEN;
    end else if (adv) begin
      if (at_end) begin
        line_q  <= '0;
        field_q <= (field_q == FIELD_EVEN) ? FIELD_ODD : FIELD_EVEN;
      end else begin
        line_q <= line_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vtg_decode.sv
module vtg_decode
  import vtg_pkg::*;
#(
  parameter int unsigned H_ACTIVE   = 1920,
  parameter int unsigned H_FRONT    = 88,
  parameter int unsigned H_SYNC     = 44,
  parameter int unsigned H_TOTAL    = 2200,
  parameter int unsigned FIELD_ROWS = 540,
  parameter int unsigned VS_LINE    = 2,
  parameter int unsigned VS_LINES   = 2,
  parameter int unsigned HW = 12,
  parameter int unsigned LW = 10,
  parameter int unsigned RW = 11
) (
  input  logic [HW-1:0] h,
  input  logic [LW-1:0] line,
  input  field_e        fld,
  output logic          de,
  output logic          hsync,
  output logic          vsync,
  output logic [RW-1:0] row
);
  localparam logic [HW-1:0] HS_ON   = HW'(H_ACTIVE + H_FRONT);
  localparam logic [HW-1:0] HS_OFF  = HW'(H_ACTIVE + H_FRONT + H_SYNC);
  localparam logic [HW-1:0] H_ACT   = HW'(H_ACTIVE);
  localparam logic [HW-1:0] H_HALF  = HW'(H_TOTAL / 2);
  localparam logic [LW-1:0] ROWS_L  = LW'(FIELD_ROWS);
  localparam logic [LW-1:0] VS_FIRST = LW'(VS_LINE);
  localparam logic [LW-1:0] VS_LAST  = LW'(VS_LINE + VS_LINES);

  logic          pic_line;
  logic [LW-1:0] bline;
  logic          odd;
  logic          vs_mid, vs_head, vs_tail;

  assign pic_line = (line < ROWS_L);
  assign bline    = line - ROWS_L;
  assign odd      = (fld == FIELD_ODD);

  assign de    = pic_line && (h < H_ACT);
  assign hsync = (h >= HS_ON) && (h < HS_OFF);
  assign row   = de ? {line[RW-2:0], odd} : '0;

  // Odd field: edges on line start; even field: edges at mid-line.
  assign vs_head = (bline == VS_FIRST) && (odd || (h >= H_HALF));
  assign vs_mid  = (bline > VS_FIRST) && (bline < VS_LAST);
  assign vs_tail = (bline == VS_LAST) && !odd && (h < H_HALF);
  assign vsync   = !pic_line && (vs_head || vs_mid || vs_tail);
endmodule

// File: rtl/vtg_interlaced.sv
module vtg_interlaced
  import vtg_pkg::*;
#(
  parameter int unsigned H_ACTIVE   = 1920,
  parameter int unsigned H_FRONT    = 88,
  parameter int unsigned H_SYNC     = 44,
  parameter int unsigned H_BACK     = 148,
  parameter int unsigned FIELD_ROWS = 540,
  parameter int unsigned BLANK_EVEN = 23,
  parameter int unsigned BLANK_ODD  = 22,
  parameter int unsigned VS_LINE    = 2,
  parameter int unsigned VS_LINES   = 2,
  localparam int unsigned H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK,
  localparam int unsigned HW = $clog2(H_TOTAL),
  localparam int unsigned LW = $clog2(FIELD_ROWS + max_u(BLANK_EVEN, BLANK_ODD)),
  localparam int unsigned RW = $clog2(2 * FIELD_ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] h_pos,
  output logic [LW-1:0] line_pos,
  output logic          field,
  output logic [RW-1:0] row,
  output logic          de,
  output logic          hsync,
  output logic          vsync
);
  logic   h_last;
  field_e fld;

  vtg_hcount #(.H_TOTAL(H_TOTAL)) u_hcount (
    .clk(clk), .rst_n(rst_n), .h_q(h_pos), .h_last(h_last)
  );

  vtg_vcount #(
    .FIELD_ROWS(FIELD_ROWS), .BLANK_EVEN(BLANK_EVEN), .BLANK_ODD(BLANK_ODD)
  ) u_vcount (
    .clk(clk), .rst_n(rst_n), .adv(h_last), .line_q(line_pos), .field_q(fld)
  );

  vtg_decode #(
    .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC), .H_TOTAL(H_TOTAL),
    .FIELD_ROWS(FIELD_ROWS), .VS_LINE(VS_LINE), .VS_LINES(VS_LINES),
    .HW(HW), .LW(LW), .RW(RW)
  ) u_decode (
    .h(h_pos), .line(line_pos), .fld(fld),
    .de(de), .hsync(hsync), .vsync(vsync), .row(row)
  );

  assign field = (fld == FIELD_ODD);
endmodule

// File: rtl/vtg_checker.sv
module vtg_checker #(
  parameter int unsigned H_ACTIVE   = 1920,
  parameter int unsigned H_FRONT    = 88,
  parameter int unsigned H_TOTAL    = 2200,
  parameter int unsigned FIELD_ROWS = 540,
  parameter int unsigned HW = 12,
  parameter int unsigned LW = 10,
  parameter int unsigned RW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic [HW-1:0] h_pos,
  input logic [LW-1:0] line_pos,
  input logic          field,
  input logic [RW-1:0] row,
  input logic          de,
  input logic          hsync,
  input logic          vsync
);
  AST_H_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (h_pos == HW'(H_TOTAL - 1)) |=> (h_pos == '0)); // R2
  AST_H_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (h_pos != HW'(H_TOTAL - 1)) |=> (h_pos == $past(h_pos) + 1'b1)); // R2
  AST_HSYNC_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync) |-> (h_pos == HW'(H_ACTIVE + H_FRONT))); // R3
  AST_DE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> ((h_pos < HW'(H_ACTIVE)) && (line_pos < LW'(FIELD_ROWS)))); // R4
  AST_ROW_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (row[0] == field)); // R5
  AST_FIELD_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(field) |-> ((line_pos == '0) && (h_pos == '0))); // R6
  AST_VS_EVEN_MID: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(vsync) && !field) |-> (h_pos == HW'(H_TOTAL / 2))); // R7
  AST_VS_ODD_START: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(vsync) && field) |-> (h_pos == '0)); // R8
  AST_VS_BLANK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |-> (line_pos >= LW'(FIELD_ROWS))); // R9
endmodule

bind vtg_interlaced vtg_checker #(
  .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_TOTAL(H_TOTAL),
  .FIELD_ROWS(FIELD_ROWS), .HW(HW), .LW(LW), .RW(RW)
) u_vtg_checker (
  .clk(clk), .rst_n(rst_n), .h_pos(h_pos), .line_pos(line_pos), .field(field),
  .row(row), .de(de), .hsync(hsync), .vsync(vsync)
);

// File: tb/vtg_interlaced_bench.sv
module vtg_interlaced_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HA = 8, HF = 2, HS = 2, HB = 4;
  localparam int HT = HA + HF + HS + HB;      // 16
  localparam int ROWS = 4, B0 = 6, B1 = 5, VSL = 2, VSN = 2;
  localparam int F0 = (ROWS + B0) * HT;        // 160
  localparam int FRAME = F0 + (ROWS + B1) * HT; // 304

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] h_pos;
  logic [3:0] line_pos;
  logic       field;
  logic [2:0] row;
  logic       de, hsync, vsync;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vtg_interlaced #(
    .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
    .FIELD_ROWS(ROWS), .BLANK_EVEN(B0), .BLANK_ODD(B1),
    .VS_LINE(VSL), .VS_LINES(VSN)
  ) u_vtg_interlaced (
    .clk(clk), .rst_n(rst_n), .h_pos(h_pos), .line_pos(line_pos), .field(field),
    .row(row), .de(de), .hsync(hsync), .vsync(vsync)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Compare every output against the position t cycles after reset.
  task automatic check_cycle(input int t);
    int p, f, q, l, h, vs_start, bp;
    bit e_de, e_hs, e_vs;
    p = t % FRAME;
    f = (p >= F0) ? 1 : 0;
    q = f ? p - F0 : p;
    l = q / HT;
    h = q % HT;
    e_de = (l < ROWS) && (h < HA);
    e_hs = (h >= HA + HF) && (h < HA + HF + HS);
    vs_start = VSL * HT + (f ? 0 : HT / 2);
    bp = (l - ROWS) * HT + h;
    e_vs = (l >= ROWS) && (bp >= vs_start) && (bp < vs_start + VSN * HT);
    check(int'(h_pos) == h, "R2 h_pos", int'(h_pos), h);
    check(int'(line_pos) == l, "R6 line_pos", int'(line_pos), l);
    check(int'(field) == f, "R6 field", int'(field), f);
    check(hsync == e_hs, "R3 hsync", int'(hsync), int'(e_hs));
    check(de == e_de, "R4 de", int'(de), int'(e_de));
    check(int'(row) == (e_de ? 2 * l + f : 0), "R5 row", int'(row), e_de ? 2 * l + f : 0);
    if (f == 0) check(vsync == e_vs, "R7 vsync even field", int'(vsync), int'(e_vs));
    else        check(vsync == e_vs, "R8 vsync odd field", int'(vsync), int'(e_vs));
  endtask

  task automatic check_origin(input string tag);
    check(h_pos == '0 && line_pos == '0 && field == 1'b0, tag,
          int'(h_pos) + int'(line_pos) + int'(field), 0);
  endtask

  initial begin : stim
    int vs_run;
    int pulses;
    vs_run = 0;
    pulses = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_origin("R1 state during reset");
    rst_n = 1'b1;
    check_origin("R1 first cycle after release");
    // Two full frames, clock by clock.
    for (int t = 0; t < 2 * FRAME; t++) begin
      check_cycle(t);
      if (vsync) vs_run++;
      else if (vs_run != 0) begin
        check(vs_run == VSN * HT, "R9 vsync pulse length", vs_run, VSN * HT);
        pulses++;
        vs_run = 0;
      end
      @(negedge clk);
    end
    check(pulses == 4, "R9 vsync pulse count", pulses, 4);
    // Reset in the middle of a frame.
    repeat (F0 + 37) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_origin("R1 mid-frame reset");
    rst_n = 1'b1;
    for (int t = 0; t < HT * 3; t++) begin
      check_cycle(t);
      @(negedge clk);
    end
    done = 1'b1;
  end

  initial begin : watchdog
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule